// File: doc/BRIEF.md
# TDM Serial Input Delay Aligner

This block takes one serial time-division-multiplexed data stream and finds where that stream's own frame starts. A reference frame pulse marks the common frame boundary. The stream itself may arrive late by a whole number of channels, by a few extra bit periods and by a fraction of a bit. The block counts ticks of a sampling clock that runs at four times the bit rate. From a packed delay word and a quarter-bit phase setting it works out where the stream's channel 0 begins, restarts its own bit and channel counters there, and samples each bit on one chosen quarter-phase tick.

Sampled bits are assembled MSB first into bytes. Each finished byte is presented with the channel number it belongs to and a one-cycle valid strobe, which a downstream switch memory or buffer can consume directly. A mode input selects a frame of 32, 64 or 128 channels. The delay word, the phase setting and the mode are all captured at a frame pulse and stay in force for the whole frame that follows.

Top module: `tdm_in_aligner`

## Requirements
- R1: After reset `byte_valid_o`, `byte_o` and `chan_o` are all zero, and no byte is reported until the stream has first been aligned after a frame pulse.
- R2: With all delays zero and phase disabled, channel 0 starts on the frame-pulse tick. Each bit lasts 4 ticks, bits arrive MSB (bit 7) first and every channel lasts 32 ticks.
- R3: The channel delay is `dly_i[9:3]`. A value of N places the stream's channel 0 N×32 ticks after the frame-pulse tick, so the last N channels of the previous frame come first.
- R4: The whole-bit delay is `dly_i[2:0]`. It adds 0 to 7 bit periods (4 ticks each) to the offset.
- R5: With `frac_en_i` low the fractional delay is zero. With it high the offset gains `frac_i`+1 ticks, a quarter to a whole bit. Each bit is sampled on the third tick of its own bit period.
- R6: The channel delay is taken modulo the current channel count. A total offset equal to the frame length wraps to 0.
- R7: `mode_i` = 0 gives 32 channels, 1 gives 64 and 2 or 3 give 128. `chan_o` counts up and wraps from the last channel to 0.
- R8: `byte_valid_o` is high for exactly one cycle per byte: the cycle after the tick that samples bit 0. It comes together with the assembled byte and its channel number.
- R9: `dly_i`, `frac_en_i`, `frac_i` and `mode_i` are captured only on a frame-pulse tick. Changes between pulses do not affect the current frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, four ticks per bit |
| rst | input | 1 | Synchronous active-high reset |
| fp_i | input | 1 | Reference frame pulse, one tick wide |
| sd_i | input | 1 | Serial stream data |
| mode_i | input | 2 | Channels per frame: 0→32, 1→64, 2/3→128 |
| dly_i | input | 10 | Channel delay [9:3], whole-bit delay [2:0] |
| frac_en_i | input | 1 | Enables the fractional delay |
| frac_i | input | 2 | Fractional delay minus one, in quarter bits |
| byte_valid_o | output | 1 | One-cycle strobe per completed byte |
| byte_o | output | 8 | Completed byte, first received bit in bit 7 |
| chan_o | output | 7 | Channel number of the completed byte |

## Verification
The assertions check several properties on every cycle. The valid strobe never lasts two cycles, and it follows every bit-0 sample. The reported channel stays inside the range of the latched mode. Nothing is reported before the stream is first aligned. A counter restart always moves the bit phase forward, and the latched mode stays constant between frame pulses. Only the bench scenarios can show that the offset lands on the right tick for each mix of channel, bit and quarter delay, including the modulo and full-frame wrap cases. They also show that bytes are reassembled with the right content and channel number, and that a delay change made mid-frame waits for the next pulse.

// File: rtl/tdm_align_pkg.sv
package tdm_align_pkg;
    parameter int CH_W   = 7;            // widest channel index (128 channels)
    parameter int QTR    = 4;            // sampling ticks per bit
    localparam int DLY_W = CH_W + 3;     // channel delay field + bit delay field
    localparam int TK_W  = CH_W + 6;     // holds a full 128-channel frame in ticks

    typedef struct packed {
        logic [1:0]      q;   // quarter within bit
        logic [2:0]      b;   // bit index, 7 first
        logic [CH_W-1:0] c;   // channel
    } pos_t;

    function automatic logic [CH_W-1:0] ch_mask(input logic [1:0] mode);
        int sh;
        sh = CH_W - 2 + ((mode > 2'd2) ? 2 : int'(mode));
        return CH_W'((1 << sh) - 1);
    endfunction

    function automatic logic [TK_W-1:0] frame_ticks(input logic [1:0] mode);
        return (TK_W'(ch_mask(mode)) + TK_W'(1)) * TK_W'(8 * QTR);
    endfunction

    function automatic logic [TK_W-1:0] offset_ticks(input logic [DLY_W-1:0] dly,
                                                     input logic fen,
                                                     input logic [1:0] frac,
                                                     input logic [1:0] mode);
        logic [TK_W-1:0] t;
        logic [TK_W-1:0] f;
        t = TK_W'(dly[DLY_W-1:3] & ch_mask(mode)) * TK_W'(8 * QTR)
          + TK_W'(dly[2:0]) * TK_W'(QTR)
          + (fen ? TK_W'(frac) + TK_W'(1) : TK_W'(0));
        f = frame_ticks(mode);
        return (t >= f) ? t - f : t;
    endfunction
endpackage

// File: rtl/tdm_offset_gen.sv
module tdm_offset_gen
    import tdm_align_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fp,
    input  logic [1:0]       mode_in,
    input  logic [DLY_W-1:0] dly,
    input  logic             fen,
    input  logic [1:0]       frac,
    output logic             restart,
    output logic [1:0]       mode_eff
);
    logic [TK_W-1:0] tcnt;
    logic [TK_W-1:0] tq;
    logic [TK_W-1:0] t_new;
    logic [1:0]      mode_q;

    assign t_new    = offset_ticks(dly, fen, frac, mode_in);
    assign mode_eff = fp ? mode_in : mode_q;
    assign restart  = fp ? (t_new == '0) : (tcnt == tq);

    always_ff @(posedge clk) begin
        if (rst) begin
            tcnt   <= '1;
            tq     <= '0;
            mode_q <= '0;
        end else if (fp) begin
            tcnt   <= TK_W'(1);
            tq     <= t_new;
            mode_q <= mode_in;
        end else if (tcnt != '1) begin
            tcnt <= tcnt + TK_W'(1);
        end
    end
endmodule

// File: rtl/tdm_pos_track.sv
module tdm_pos_track
    import tdm_align_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       restart,
    input  logic [1:0] mode_eff,
    output pos_t       cur,
    output logic       locked,
    output logic       sample,
    output logic       byte_done
);
    pos_t pos_r;
    pos_t nxt;
    logic lock_r;

    always_comb begin
        if (restart) begin
            cur.q = '0;
            cur.b = 3'd7;
            cur.c = '0;
        end else begin
            cur = pos_r;
        end
        nxt   = cur;
        nxt.q = cur.q + 2'd1;
        if (cur.q == 2'(QTR - 1)) begin
            nxt.b = cur.b - 3'd1;
            if (cur.b == 3'd0)
                nxt.c = (cur.c == ch_mask(mode_eff)) ? '0 : cur.c + CH_W'(1);
        end
    end

    assign locked    = lock_r | restart;
    assign sample    = locked && (cur.q == 2'd2);
    assign byte_done = sample && (cur.b == 3'd0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_r  <= '0;
            lock_r <= 1'b0;
        end else begin
            pos_r  <= nxt;
            lock_r <= locked;
        end
    end
endmodule

// File: rtl/tdm_byte_deser.sv
module tdm_byte_deser
    import tdm_align_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sample,
    input  logic            byte_done,
    input  logic            sd,
    input  logic [CH_W-1:0] ch_in,
    output logic            valid,
    output logic [7:0]      data,
    output logic [CH_W-1:0] ch_out
);
    logic [6:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh     <= '0;
            valid  <= 1'b0;
            data   <= '0;
            ch_out <= '0;
        end else begin
            if (sample)
                sh <= {sh[5:0], sd};
            valid <= byte_done;
            if (byte_done) begin
                data   <= {sh, sd};
                ch_out <= ch_in;
            end
        end
    end
endmodule

// File: rtl/tdm_in_aligner.sv
module tdm_in_aligner
    import tdm_align_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fp_i,
    input  logic             sd_i,
    input  logic [1:0]       mode_i,
    input  logic [DLY_W-1:0] dly_i,
    input  logic             frac_en_i,
    input  logic [1:0]       frac_i,
    output logic             byte_valid_o,
    output logic [7:0]       byte_o,
    output logic [CH_W-1:0]  chan_o
);
    logic       restart;
    logic [1:0] mode_eff;
    pos_t       cur;
    logic       locked;
    logic       sample;
    logic       byte_done;

    tdm_offset_gen u_off (
        .clk(clk), .rst(rst), .fp(fp_i), .mode_in(mode_i), .dly(dly_i),
        .fen(frac_en_i), .frac(frac_i), .restart(restart), .mode_eff(mode_eff)
    );

    tdm_pos_track u_trk (
        .clk(clk), .rst(rst), .restart(restart), .mode_eff(mode_eff),
        .cur(cur), .locked(locked), .sample(sample), .byte_done(byte_done)
    );

    tdm_byte_deser u_des (
        .clk(clk), .rst(rst), .sample(sample), .byte_done(byte_done),
        .sd(sd_i), .ch_in(cur.c), .valid(byte_valid_o), .data(byte_o),
        .ch_out(chan_o)
    );
endmodule

// File: rtl/tdm_in_aligner_chk.sv
module tdm_in_aligner_chk
    import tdm_align_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            fp,
    input logic            restart,
    input logic            locked,
    input logic            byte_done,
    input logic [1:0]      mode_eff,
    input pos_t            cur,
    input logic            valid,
    input logic [CH_W-1:0] chan
);
    // R8
    valid_single_chk: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);
    // R8
    valid_after_bit0_chk: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> valid);
    // R7
    chan_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        valid |-> ((chan & ~ch_mask(mode_eff)) == '0));
    // R1
    quiet_before_lock_chk: assert property (@(posedge clk) disable iff (rst)
        !locked |=> !valid);
    // R3
    restart_advance_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (restart || cur.q == 2'd1));
    // R9
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !fp |=> (fp || $stable(mode_eff)));
endmodule

bind tdm_in_aligner tdm_in_aligner_chk u_chk (
    .clk(clk), .rst(rst), .fp(fp_i), .restart(restart), .locked(locked),
    .byte_done(byte_done), .mode_eff(mode_eff), .cur(cur),
    .valid(byte_valid_o), .chan(chan_o)
);

// File: tb/tb_tdm_in_aligner.sv
module tb_tdm_in_aligner;
    logic       clk = 1'b0;
    logic       rst;
    logic       fp_i, sd_i, frac_en_i;
    logic [1:0] mode_i, frac_i;
    logic [9:0] dly_i;
    logic       byte_valid_o;
    logic [7:0] byte_o;
    logic [6:0] chan_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // bench model state
    int ft, fr_len, tsince, tq, p, salt;
    bit lk;

    always #5 clk = ~clk;

    tdm_in_aligner dut (
        .clk(clk), .rst(rst), .fp_i(fp_i), .sd_i(sd_i), .mode_i(mode_i),
        .dly_i(dly_i), .frac_en_i(frac_en_i), .frac_i(frac_i),
        .byte_valid_o(byte_valid_o), .byte_o(byte_o), .chan_o(chan_o)
    );

    // {mode, chdly(7), bdly(3), fen, frac, salt}
    localparam int NV = 8;
    localparam logic [22:0] VEC [NV] = '{
        {2'd0, 7'd0,   3'd0, 1'b0, 2'd0, 8'h11},  // R2 default
        {2'd0, 7'd2,   3'd0, 1'b0, 2'd0, 8'h22},  // R3
        {2'd0, 7'd0,   3'd3, 1'b1, 2'd1, 8'h33},  // R4 R5
        {2'd1, 7'd63,  3'd7, 1'b1, 2'd3, 8'h44},  // R6 full-frame wrap
        {2'd2, 7'd100, 3'd5, 1'b1, 2'd0, 8'h55},  // R7 128 ch
        {2'd0, 7'd40,  3'd2, 1'b0, 2'd0, 8'h66},  // R6 modulo
        {2'd1, 7'd31,  3'd0, 1'b1, 2'd2, 8'h77},  // R5 R7
        {2'd3, 7'd127, 3'd7, 1'b0, 2'd0, 8'h88}   // R7 mode 3
    };

    function automatic int nch(input logic [1:0] m);
        return (m == 2'd0) ? 32 : (m == 2'd1) ? 64 : 128;
    endfunction

    function automatic int calc_t(input logic [9:0] d, input logic fe,
                                  input logic [1:0] fr, input logic [1:0] m);
        int t;
        t = ((int'(d[9:3]) % nch(m)) * 32) + int'(d[2:0]) * 4 + (fe ? int'(fr) + 1 : 0);
        return t % (nch(m) * 32);
    endfunction

    function automatic logic [7:0] pat(input int ch, input int s);
        int v;
        v = ch * 29 + s;
        return v[7:0];
    endfunction

    task automatic check(input bit ok, input string req, input string msg);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    // one sampling tick: drive on negedge, compare after the posedge
    task automatic tick(input string req);
        bit ev;
        int ech;
        logic [7:0] exd;
        logic [7:0] cur_b;
        @(negedge clk);
        fp_i = (ft == 0);
        if (fp_i) begin
            tq     = calc_t(dly_i, frac_en_i, frac_i, mode_i);
            fr_len = nch(mode_i) * 32;
            tsince = 0;
        end else if (tsince < 100000) begin
            tsince++;
        end
        if (tsince == tq) begin
            p  = 0;
            lk = 1;
        end
        cur_b = pat(p / 32, salt);
        sd_i  = lk ? cur_b[7 - (p % 32) / 4] : 1'b0;
        ev    = lk && (p % 32 == 30);
        ech   = p / 32;
        exd   = cur_b;
        @(posedge clk);
        #1;
        if (ev || byte_valid_o) begin
            check(byte_valid_o == ev, req,
                  $sformatf("valid act=%0b exp=%0b", byte_valid_o, ev));
            if (ev) begin
                check(chan_o == 7'(ech) && byte_o == exd, req,
                      $sformatf("ch/byte act=%0d/%h exp=%0d/%h", chan_o, byte_o, ech, exd));
            end
        end
        if (lk) p = (p + 1) % fr_len;
        ft = (ft + 1) % fr_len;
    endtask

    task automatic do_reset(input logic [1:0] m);
        @(negedge clk);
        rst = 1'b1; fp_i = 1'b0; sd_i = 1'b0; mode_i = m;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        lk = 0; p = 0; tsince = 100000; tq = -1;
        fr_len = nch(m) * 32;
        ft = fr_len - 5;
    endtask

    initial begin
        rst = 1'b1; fp_i = 0; sd_i = 0; mode_i = 0; dly_i = 0;
        frac_en_i = 0; frac_i = 0; salt = 0;

        // R1 reset state
        do_reset(2'd0);
        #1;
        check(byte_valid_o == 0 && byte_o == 0 && chan_o == 0, "R1",
              $sformatf("reset outs act=%0b/%h/%0d exp=0/00/0", byte_valid_o, byte_o, chan_o));
        for (int i = 0; i < 4; i++) tick("R1");

        // table-driven scenarios
        for (int v = 0; v < NV; v++) begin
            logic [22:0] e;
            e = VEC[v];
            do_reset(e[22:21]);
            dly_i     = e[20:11];
            frac_en_i = e[10];
            frac_i    = e[9:8];
            salt      = int'(e[7:0]);
            for (int k = 0; k < 2 * nch(e[22:21]) * 32 + 40; k++)
                tick($sformatf("R2 R3 R4 R5 R6 R7 R8 vec%0d", v));
        end

        // R9: delay changed mid-frame, takes effect at next pulse
        do_reset(2'd0);
        dly_i = {7'd1, 3'd0}; frac_en_i = 0; frac_i = 0; salt = 9;
        for (int k = 0; k < 1024 + 500; k++) tick("R9");
        dly_i = {7'd5, 3'd6}; frac_en_i = 1; frac_i = 2'd1;
        for (int k = 0; k < 2048; k++) tick("R9");

        // R7 channel wrap seen at the ports in 32-channel mode
        begin
            int last_ch;
            bit seen;
            seen = 0;
            last_ch = -1;
            do_reset(2'd0);
            dly_i = 0; frac_en_i = 0; salt = 3;
            for (int k = 0; k < 2100; k++) begin
                tick("R7");
                if (byte_valid_o) begin
                    if (last_ch == 31 && chan_o == 0) seen = 1;
                    last_ch = int'(chan_o);
                end
            end
            check(seen, "R7", $sformatf("wrap 31->0 act=%0b exp=1", seen));
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule